// File: doc/BRIEF.md
# Aperture Address Remapper

This block translates one master's address into a target-slave code and a rewritten address. The upper nibble of the input address picks one of sixteen equal apertures. A small table gives two values for each aperture: the slave that receives the access, and the aperture index that is used inside that slave's own address space. The rewritten address is that index placed above the untouched lower address bits. Any aperture can be sent to any target aperture, so the map does not have to be the identity.

Software programs the table through a simple register port (enable, write, address, write data, read data). Writes to the table fill a shadow copy, and the translation keeps using the active copy. A write of 1 to a separate commit register copies the whole shadow table into the active table on that clock edge, so the map changes in one step. A read-only status bit reports when the shadow copy differs from the active copy. An aperture whose slave code is zero maps to no target. An access to such an aperture raises a decode error in the same cycle instead of a slave-valid.

Top module: `aperture_remap`

## Requirements
- R1: The aperture index is in_addr[31:28]. out_addr is the active 4-bit target-aperture index of that aperture joined above in_addr[27:0].
- R2: out_slave is the active 4-bit slave code of the addressed aperture. out_valid is 1 exactly when in_valid is 1 and that code is not 0, in the same cycle with no register on the path.
- R3: decode_err is 1 exactly when in_valid is 1 and the addressed aperture's active slave code is 0. out_valid and decode_err are never 1 together.
- R4: Register layout (word-aligned byte addresses): 0x00 holds slave codes for apertures 0-7 and 0x04 holds them for apertures 8-15. 0x08 holds target indices for apertures 0-7 and 0x0C holds them for apertures 8-15. In each word, aperture i occupies bits [4*(i mod 8)+3 : 4*(i mod 8)]. A write happens on the rising edge where cfg_en=1 and cfg_we=1.
- R5: Writes to 0x00-0x0C change only the shadow table. The translation outputs do not change until a commit.
- R6: A write to 0x10 with bit 0 = 1 copies the whole shadow table into the active table on that edge. An access in the cycle of that write uses the old map, and the next cycle uses the new one. A write to 0x10 with bit 0 = 0 has no effect.
- R7: With cfg_en=1 and cfg_we=0, cfg_rdata returns the shadow word at 0x00-0x0C in the same cycle. It returns 0 at 0x10, at unmapped or unaligned addresses, and whenever cfg_en=0. Reads change no state.
- R8: A read at 0x14 returns bit 0 = 1 when the shadow and active tables differ, and 0 in all other bits. Writes to 0x14 are ignored.
- R9: After reset, both tables are all zero. Every valid access therefore gives a decode error, and the status bit is 0. rst_n asserts asynchronously, and its release takes effect after two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Register access enable |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 5 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| in_valid | input | 1 | Lookup request valid |
| in_addr | input | 32 | Master address |
| out_valid | output | 1 | Access routed to a slave |
| out_slave | output | 4 | Slave code of addressed aperture |
| out_addr | output | 32 | Remapped address |
| decode_err | output | 1 | Access hit an unmapped aperture |

## Verification
The assertions assume that register accesses are single-cycle and carry known address and enable values. They also assume that a commit and a table write never share a cycle, which the one-access-per-cycle port already guarantees. The stimulus changes inputs only on the falling clock edge, keeps every register address word-aligned except in one deliberate unaligned read, and waits for the two-edge reset release before the first access. It then checks each aperture against a model that the bench builds from the register writes it has issued.

// File: rtl/aprm_pkg.sv
package aprm_pkg;
  localparam int APRM_ADDR_W = 32;
  localparam int APRM_FLD_W  = 4;
  localparam int APRM_DATA_W = 32;
  localparam int APRM_CFG_AW = 5;

  // word index of register groups, given the number of words per table
  function automatic int sel_base(input int words);
    return 0;
  endfunction
  function automatic int off_base(input int words);
    return words;
  endfunction
  function automatic int upd_idx(input int words);
    return 2 * words;
  endfunction
  function automatic int sts_idx(input int words);
    return 2 * words + 1;
  endfunction
endpackage

// File: rtl/aprm_rst_sync.sv
module aprm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/aprm_regs.sv
module aprm_regs
  import aprm_pkg::*;
#(
  parameter int FLD_W  = APRM_FLD_W,
  parameter int DATA_W = APRM_DATA_W,
  parameter int CFG_AW = APRM_CFG_AW
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_en,
  input  logic                          cfg_we,
  input  logic [CFG_AW-1:0]             cfg_addr,
  input  logic [DATA_W-1:0]             cfg_wdata,
  output logic [DATA_W-1:0]             cfg_rdata,
  output logic [(1<<FLD_W)*FLD_W-1:0]   act_sel,
  output logic [(1<<FLD_W)*FLD_W-1:0]   act_off
);
  localparam int NUM_APER = 1 << FLD_W;
  localparam int TBL_W    = NUM_APER * FLD_W;
  localparam int WORDS    = TBL_W / DATA_W;
  localparam int WIDX_W   = CFG_AW - 2;
  localparam logic [WIDX_W-1:0] UPD_W = WIDX_W'(upd_idx(WORDS));
  localparam logic [WIDX_W-1:0] STS_W = WIDX_W'(sts_idx(WORDS));

  logic [TBL_W-1:0] shd_sel_q, shd_sel_d, shd_off_q, shd_off_d;
  logic [TBL_W-1:0] act_sel_q, act_off_q;
  logic [WIDX_W-1:0] widx;
  logic aligned, wr_en, rd_en, commit, pending;

  assign widx    = cfg_addr[CFG_AW-1:2];
  assign aligned = (cfg_addr[1:0] == 2'b00);
  assign wr_en   = cfg_en & cfg_we & aligned;
  assign rd_en   = cfg_en & ~cfg_we & aligned;
  assign commit  = wr_en & (widx == UPD_W) & cfg_wdata[0];
  assign pending = (shd_sel_q != act_sel_q) | (shd_off_q != act_off_q);

  // next-state of the shadow table
  always_comb begin
    shd_sel_d = shd_sel_q;
    shd_off_d = shd_off_q;
    for (int k = 0; k < WORDS; k++) begin
      if (wr_en && widx == WIDX_W'(sel_base(WORDS) + k))
        shd_sel_d[k*DATA_W +: DATA_W] = cfg_wdata;
      if (wr_en && widx == WIDX_W'(off_base(WORDS) + k))
        shd_off_d[k*DATA_W +: DATA_W] = cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_sel_q <= '0;
      shd_off_q <= '0;
    end else if (wr_en) begin
      shd_sel_q <= shd_sel_d;
      shd_off_q <= shd_off_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_sel_q <= '0;
      act_off_q <= '0;
    end else if (commit) begin
      act_sel_q <= shd_sel_q;
      act_off_q <= shd_off_q;
    end
  end

  // read mux: shadow words, status word, zero elsewhere
  always_comb begin
    cfg_rdata = '0;
    if (rd_en) begin
      for (int k = 0; k < WORDS; k++) begin
        if (widx == WIDX_W'(sel_base(WORDS) + k)) cfg_rdata = shd_sel_q[k*DATA_W +: DATA_W];
        if (widx == WIDX_W'(off_base(WORDS) + k)) cfg_rdata = shd_off_q[k*DATA_W +: DATA_W];
      end
      if (widx == STS_W) cfg_rdata = DATA_W'(pending);
    end
  end

  assign act_sel = act_sel_q;
  assign act_off = act_off_q;

  // R5/R6: the active map only moves on a commit
  p_active_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(act_sel_q) && $stable(act_off_q)));
  // R6: after a commit both copies agree
  p_commit_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !pending);
  // R7: reads leave the shadow table alone
  p_read_no_effect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && !cfg_we) |=> ($stable(shd_sel_q) && $stable(shd_off_q)));
  // R8: status write changes nothing
  p_status_wr_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == STS_W) |=> ($stable(shd_sel_q) && $stable(act_sel_q)));
endmodule

// File: rtl/aprm_lookup.sv
module aprm_lookup
  import aprm_pkg::*;
#(
  parameter int ADDR_W = APRM_ADDR_W,
  parameter int FLD_W  = APRM_FLD_W
) (
  input  logic                        in_valid,
  input  logic [ADDR_W-1:0]           in_addr,
  input  logic [(1<<FLD_W)*FLD_W-1:0] act_sel,
  input  logic [(1<<FLD_W)*FLD_W-1:0] act_off,
  output logic                        out_valid,
  output logic [FLD_W-1:0]            out_slave,
  output logic [ADDR_W-1:0]           out_addr,
  output logic                        decode_err
);
  localparam int NUM_APER = 1 << FLD_W;
  localparam int LOW_W    = ADDR_W - FLD_W;

  logic [FLD_W-1:0] aper;
  logic [FLD_W-1:0] sel_mux [NUM_APER];
  logic [FLD_W-1:0] off_mux [NUM_APER];
  logic [FLD_W-1:0] tgt;

  assign aper = in_addr[ADDR_W-1 -: FLD_W];

  for (genvar g = 0; g < NUM_APER; g++) begin : g_unpack
    assign sel_mux[g] = act_sel[g*FLD_W +: FLD_W];
    assign off_mux[g] = act_off[g*FLD_W +: FLD_W];
  end

  assign out_slave  = sel_mux[aper];
  assign tgt        = off_mux[aper];
  assign out_addr   = {tgt, in_addr[LOW_W-1:0]};
  assign out_valid  = in_valid & (out_slave != '0);
  assign decode_err = in_valid & (out_slave == '0);
endmodule

// File: rtl/aperture_remap.sv
module aperture_remap
  import aprm_pkg::*;
#(
  parameter int ADDR_W = APRM_ADDR_W,
  parameter int FLD_W  = APRM_FLD_W,
  parameter int DATA_W = APRM_DATA_W,
  parameter int CFG_AW = APRM_CFG_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  output logic [FLD_W-1:0]  out_slave,
  output logic [ADDR_W-1:0] out_addr,
  output logic              decode_err
);
  localparam int TBL_W = (1 << FLD_W) * FLD_W;

  logic             rst_sync_n;
  logic [TBL_W-1:0] act_sel, act_off;

  aprm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  aprm_regs #(.FLD_W(FLD_W), .DATA_W(DATA_W), .CFG_AW(CFG_AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_en    (cfg_en),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .act_sel   (act_sel),
    .act_off   (act_off)
  );

  aprm_lookup #(.ADDR_W(ADDR_W), .FLD_W(FLD_W)) u_lookup (
    .in_valid   (in_valid),
    .in_addr    (in_addr),
    .act_sel    (act_sel),
    .act_off    (act_off),
    .out_valid  (out_valid),
    .out_slave  (out_slave),
    .out_addr   (out_addr),
    .decode_err (decode_err)
  );

  // R3: routed and error never together
  p_err_excl_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(out_valid && decode_err));
  // R2/R3: every valid lookup resolves to exactly one outcome
  p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |-> (out_valid || decode_err));
  // R1: low address bits pass through untouched
  p_low_bits_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_addr[ADDR_W-FLD_W-1:0] == in_addr[ADDR_W-FLD_W-1:0]);
endmodule

// File: tb/test_aperture_remap.sv
module test_aperture_remap;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_en, cfg_we;
  logic [4:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        in_valid;
  logic [31:0] in_addr, out_addr;
  logic        out_valid, decode_err;
  logic [3:0]  out_slave;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [63:0] shd_sel_m, shd_off_m, act_sel_m, act_off_m;

  always #5 clk = ~clk;

  aperture_remap i_aperture_remap (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .in_valid(in_valid), .in_addr(in_addr), .out_valid(out_valid),
    .out_slave(out_slave), .out_addr(out_addr), .decode_err(decode_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // translation check against the active model (R1 R2 R3)
  task automatic xl(input logic v, input logic [31:0] a, input string tag);
    logic [3:0] ap, s, o;
    in_valid = v;
    in_addr  = a;
    #1;
    ap = a[31:28];
    s  = act_sel_m[ap*4 +: 4];
    o  = act_off_m[ap*4 +: 4];
    chk({tag, " R2 slave"}, 32'(out_slave), 32'(s));
    chk({tag, " R1 addr"}, out_addr, {o, a[27:0]});
    chk({tag, " R2 valid"}, 32'(out_valid), 32'(v && s != 4'd0));
    chk({tag, " R3 err"}, 32'(decode_err), 32'(v && s == 4'd0));
  endtask

  task automatic cfg_wr(input logic [4:0] a, input logic [31:0] d);
    cfg_en = 1; cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_en = 0; cfg_we = 0;
    case (a)
      5'h00: shd_sel_m[31:0]  = d;
      5'h04: shd_sel_m[63:32] = d;
      5'h08: shd_off_m[31:0]  = d;
      5'h0C: shd_off_m[63:32] = d;
      5'h10: if (d[0]) begin act_sel_m = shd_sel_m; act_off_m = shd_off_m; end
      default: ;
    endcase
  endtask

  task automatic cfg_rd(input logic [4:0] a, output logic [31:0] d);
    cfg_en = 1; cfg_we = 0; cfg_addr = a;
    #1 d = cfg_rdata;
    @(negedge clk);
    cfg_en = 0;
  endtask

  function automatic logic [31:0] exp_status();
    return 32'((shd_sel_m != act_sel_m) || (shd_off_m != act_off_m));
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    for (int i = 0; i < 6; i++) begin
      cfg_rd(5'(i * 4), d);
      chk($sformatf("R9 reset read %0h", i * 4), d, 32'h0);
    end
    xl(1'b1, 32'h5123_4567, "R9 reset lookup");
    xl(1'b1, 32'hF000_0000, "R9 reset lookup top");
  endtask

  task automatic t_shadow;
    logic [31:0] d;
    cfg_wr(5'h00, 32'h1230_0456);
    cfg_wr(5'h04, 32'h7600_2301);
    cfg_wr(5'h08, 32'h3210_0765);
    cfg_wr(5'h0C, 32'hFED0_0BA0);
    cfg_rd(5'h00, d); chk("R7 read sel lo", d, 32'h1230_0456);
    cfg_rd(5'h04, d); chk("R7 read sel hi", d, 32'h7600_2301);
    cfg_rd(5'h08, d); chk("R7 read off lo", d, 32'h3210_0765);
    cfg_rd(5'h0C, d); chk("R7 read off hi", d, 32'hFED0_0BA0);
    cfg_rd(5'h14, d); chk("R8 status pending", d, 32'h1);
    xl(1'b1, 32'h0ABC_DEF0, "R5 uncommitted ap0");
    xl(1'b1, 32'h8000_0010, "R5 uncommitted ap8");
  endtask

  task automatic t_commit;
    logic [31:0] d;
    cfg_wr(5'h10, 32'hFFFF_FFFE);
    cfg_rd(5'h14, d); chk("R6 bit0 clear no commit", d, 32'h1);
    xl(1'b1, 32'h8000_0010, "R6 bit0 clear lookup");
    cfg_en = 1; cfg_we = 1; cfg_addr = 5'h10; cfg_wdata = 32'h1;
    xl(1'b1, 32'h8000_0010, "R6 same cycle old map");
    @(negedge clk);
    cfg_en = 0; cfg_we = 0;
    act_sel_m = shd_sel_m; act_off_m = shd_off_m;
    xl(1'b1, 32'h8000_0010, "R6 next cycle new map");
    cfg_rd(5'h14, d); chk("R8 status after commit", d, 32'h0);
    cfg_rd(5'h10, d); chk("R7 commit reg reads zero", d, 32'h0);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 16; i++)
      xl(1'b1, {4'(i), 28'(32'h0A5C_3E1 * (i + 1))}, $sformatf("R1 sweep ap%0d", i));
    xl(1'b0, 32'h0123_4567, "R2 idle ap0");
    xl(1'b0, 32'h3000_0000, "R3 idle unmapped");
    // ap8 -> slave 1, target aperture 0 (R4 nibble 0 of 0x04 / 0x0C)
    xl(1'b1, 32'h8765_4321, "R4 ap8 remapped");
    chk("R4 ap8 target 0", out_addr, 32'h0765_4321);
  endtask

  task automatic t_ignored;
    logic [31:0] d;
    cfg_wr(5'h14, 32'hFFFF_FFFF);
    cfg_rd(5'h14, d); chk("R8 status write ignored", d, 32'h0);
    cfg_rd(5'h00, d); chk("R8 sel lo untouched", d, 32'h1230_0456);
    cfg_rd(5'h01, d); chk("R7 unaligned reads zero", d, 32'h0);
    cfg_rd(5'h18, d); chk("R7 unmapped reads zero", d, 32'h0);
    cfg_addr = 5'h00; #1;
    chk("R7 disabled reads zero", cfg_rdata, 32'h0);
    cfg_wr(5'h04, 32'h0000_0005);
    cfg_rd(5'h14, d); chk("R8 status after new write", d, exp_status());
    xl(1'b1, 32'h9000_0001, "R5 hi write pending ap9");
    xl(1'b1, 32'h8000_0001, "R5 hi write pending ap8");
    cfg_wr(5'h10, 32'h1);
    xl(1'b1, 32'h8000_0001, "R6 second commit ap8");
    xl(1'b1, 32'h9000_0001, "R6 second commit ap9");
  endtask

  initial begin
    shd_sel_m = '0; shd_off_m = '0; act_sel_m = '0; act_off_m = '0;
    cfg_en = 0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
    in_valid = 0; in_addr = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_shadow();
    t_commit();
    t_sweep();
    t_ignored();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule